// File: doc/BRIEF.md
# Chained direct-mapped instruction store

This block is a small store of preloaded 32-bit instructions for a fetch unit. It is placed by address the way a direct-mapped cache is, but every entry also carries a pointer to another entry. When several hot instructions want the same slot, one of them keeps it and the others go into free slots, reached by following those pointers. A loader fills the entries through a write port before fetching begins. Run-time replacement is not part of the block.

A fetch request splits its address into three fields: the offset, which is ignored; the index, which picks the first entry to look at; and the tag, which is compared. The block then checks one entry per clock cycle. It stops at the first tag match, which is a hit. It also stops at an entry that has no pointer, which is a miss, and the fetch unit then goes to main memory. The valid bit is only examined on the first entry. An entry reached through a pointer is accepted on its tag alone. Each response is a one-cycle pulse that carries the hit flag, the instruction, and the number of entries examined. The walk is capped at the entry count, so a looping chain still ends.

Top module: `linkcache_fetch`

## Requirements
- R1: After reset, `ready` is 1, and `done` and `hit` are 0.
- R2: The fetch address is split as follows: the tag is `addr[31:5]` and the index is `addr[4:2]`. Bits `addr[1:0]` have no effect on the result.
- R3: If the entry selected by the index has its valid bit at 0, the response is a miss with `probes` = 1. This holds even if that entry's tag matches or its link is set.
- R4: If the selected entry is valid and its tag matches, the response is a hit that returns its instruction, with `probes` = 1.
- R5: On a tag mismatch, when the current entry's link is set, the entry that the link names is examined next. An entry reached through a link is accepted on a tag match whatever its valid bit is. A hit at the k-th entry examined reports `probes` = k.
- R6: On a tag mismatch at an entry whose link is not set, the response is a miss, and `probes` equals the number of entries examined.
- R7: A walk examines at most 8 entries. A chain that loops ends as a miss with `probes` = 8.
- R8: `done` is high for exactly one cycle per accepted request. It rises N cycles after the accepting clock edge, where N is the reported `probes`. `hit` and `instr` are 0 whenever `done` is 0, and `instr` is 0 on a miss.
- R9: A request is accepted only on a clock edge where `req` and `ready` are both 1. `ready` is 0 while a walk is in progress. A `req` seen while `ready` is 0 is dropped and produces no response.
- R10: A write with `wr_en` = 1 replaces all four fields of the entry at `wr_idx` from the next clock edge. Those fields are the valid bit, the tag, the instruction, and the link. The link is not set when `wr_link_ok` = 0, and names `wr_link` when `wr_link_ok` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Fetch request |
| addr | input | 32 | Fetch address |
| ready | output | 1 | Idle, able to accept a request |
| done | output | 1 | One-cycle response pulse |
| hit | output | 1 | Response is a hit |
| instr | output | 32 | Instruction on a hit, 0 otherwise |
| probes | output | 4 | Entries examined for this response |
| wr_en | input | 1 | Loader write strobe |
| wr_idx | input | 3 | Entry to write |
| wr_valid | input | 1 | Valid bit to store |
| wr_tag | input | 27 | Tag to store |
| wr_instr | input | 32 | Instruction to store |
| wr_link_ok | input | 1 | Link present |
| wr_link | input | 3 | Linked entry index |

## Verification
Two situations are the hardest to reach from the ports. The first is a runaway walk, which needs a chain of links that forms a loop. The second is a hit on an entry whose valid bit is 0. The loader writes a two-entry cycle and a three-long chain whose tail entries are marked invalid. Lookups then target each position in that chain, a tag absent from the loop, and an invalid head whose tag still matches. A second request is also raised in the middle of a multi-cycle walk, to show that it is dropped.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic {
    WALK_IDLE  = 1'b0,
    WALK_PROBE = 1'b1
  } walk_state_e;
endpackage

// File: rtl/lc_store.sv
module lc_store #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3,
  parameter int TAG_W   = 27,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_link_ok,
  input  logic [IDX_W-1:0]  wr_link,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_link_ok,
  output logic [IDX_W-1:0]  rd_link
);
  logic              valid_q   [ENTRIES];
  logic [TAG_W-1:0]  tag_q     [ENTRIES];
  logic [DATA_W-1:0] data_q    [ENTRIES];
  logic              link_ok_q [ENTRIES];
  logic [IDX_W-1:0]  link_q    [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[e]   <= 1'b0;
        tag_q[e]     <= '0;
        data_q[e]    <= '0;
        link_ok_q[e] <= 1'b0;
        link_q[e]    <= '0;
      end else if (sel) begin
        valid_q[e]   <= wr_valid;
        tag_q[e]     <= wr_tag;
        data_q[e]    <= wr_data;
        link_ok_q[e] <= wr_link_ok;
        link_q[e]    <= wr_link;
      end
    end
  end

  assign rd_valid   = valid_q[rd_idx];
  assign rd_tag     = tag_q[rd_idx];
  assign rd_data    = data_q[rd_idx];
  assign rd_link_ok = link_ok_q[rd_idx];
  assign rd_link    = link_q[rd_idx];
endmodule

// File: rtl/lc_walker.sv
module lc_walker
  import lc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3,
  parameter int TAG_W   = 27,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TAG_W-1:0]  start_tag,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic              ent_valid,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [DATA_W-1:0] ent_data,
  input  logic              ent_link_ok,
  input  logic [IDX_W-1:0]  ent_link,
  output logic [IDX_W-1:0]  probe_idx,
  output logic              ready,
  output logic              done,
  output logic              hit,
  output logic [DATA_W-1:0] instr,
  output logic [CNT_W-1:0]  probes,
  output logic              probe_active,
  output logic              probe_first,
  output logic              probe_match,
  output logic              probe_stop
);
  walk_state_e      state_q;
  logic [TAG_W-1:0] tag_q;
  logic [IDX_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             first_q;
  logic [CNT_W-1:0] cnt_next;
  logic             probe_dead;

  // a chained entry is trusted on its tag; only the head needs its valid bit
  function automatic logic entry_accepts(input logic is_head, input logic vld,
                                         input logic [TAG_W-1:0] have,
                                         input logic [TAG_W-1:0] want);
    return (have == want) && (vld || !is_head);
  endfunction

  function automatic logic may_follow(input logic link_ok, input logic [CNT_W-1:0] seen);
    return link_ok && (seen < CNT_W'(ENTRIES));
  endfunction

  assign probe_active = (state_q == WALK_PROBE);
  assign probe_first  = probe_active && first_q;
  assign cnt_next     = cnt_q + CNT_W'(1);
  assign probe_dead   = probe_first && !ent_valid;
  assign probe_match  = probe_active && entry_accepts(first_q, ent_valid, ent_tag, tag_q);
  assign probe_stop   = probe_active &&
                        (probe_dead || probe_match || !may_follow(ent_link_ok, cnt_next));
  assign ready        = (state_q == WALK_IDLE);
  assign probe_idx    = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      tag_q   <= '0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      first_q <= 1'b0;
      done    <= 1'b0;
      hit     <= 1'b0;
      instr   <= '0;
      probes  <= '0;
    end else begin
      done  <= 1'b0;
      hit   <= 1'b0;
      instr <= '0;
      case (state_q)
        WALK_IDLE: begin
          if (start) begin
            tag_q   <= start_tag;
            ptr_q   <= start_idx;
            cnt_q   <= '0;
            first_q <= 1'b1;
            state_q <= WALK_PROBE;
          end
        end
        WALK_PROBE: begin
          cnt_q   <= cnt_next;
          first_q <= 1'b0;
          ptr_q   <= ent_link;
          if (probe_stop) begin
            state_q <= WALK_IDLE;
            done    <= 1'b1;
            hit     <= probe_match;
            instr   <= probe_match ? ent_data : '0;
            probes  <= cnt_next;
          end
        end
        default: state_q <= WALK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/linkcache_fetch.sv
module linkcache_fetch #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int OFF_W   = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic              ready,
  output logic              done,
  output logic              hit,
  output logic [DATA_W-1:0] instr,
  output logic [CNT_W-1:0]  probes,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_instr,
  input  logic              wr_link_ok,
  input  logic [IDX_W-1:0]  wr_link
);
  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W+OFF_W];
  endfunction

  function automatic logic [IDX_W-1:0] addr_index(input logic [ADDR_W-1:0] a);
    return a[IDX_W+OFF_W-1:OFF_W];
  endfunction

  logic              unused_offset;
  logic              req_accept;
  logic [IDX_W-1:0]  probe_idx;
  logic              ent_valid;
  logic [TAG_W-1:0]  ent_tag;
  logic [DATA_W-1:0] ent_data;
  logic              ent_link_ok;
  logic [IDX_W-1:0]  ent_link;
  logic              probe_active;
  logic              probe_first;
  logic              probe_match;
  logic              probe_stop;

  assign unused_offset = ^addr[OFF_W-1:0];
  assign req_accept    = req && ready;

  lc_store #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_tag(wr_tag),
    .wr_data(wr_instr), .wr_link_ok(wr_link_ok), .wr_link(wr_link),
    .rd_idx(probe_idx), .rd_valid(ent_valid), .rd_tag(ent_tag),
    .rd_data(ent_data), .rd_link_ok(ent_link_ok), .rd_link(ent_link)
  );

  lc_walker #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_walker (
    .clk(clk), .rst_n(rst_n),
    .start(req_accept), .start_tag(addr_tag(addr)), .start_idx(addr_index(addr)),
    .ent_valid(ent_valid), .ent_tag(ent_tag), .ent_data(ent_data),
    .ent_link_ok(ent_link_ok), .ent_link(ent_link),
    .probe_idx(probe_idx), .ready(ready), .done(done), .hit(hit),
    .instr(instr), .probes(probes),
    .probe_active(probe_active), .probe_first(probe_first),
    .probe_match(probe_match), .probe_stop(probe_stop)
  );
endmodule

// File: rtl/linkcache_fetch_chk.sv
module linkcache_fetch_chk #(
  parameter int ENTRIES = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_accept,
  input logic              ready,
  input logic              done,
  input logic              hit,
  input logic [DATA_W-1:0] instr,
  input logic [CNT_W-1:0]  probes,
  input logic              probe_active,
  input logic              probe_first,
  input logic              ent_valid
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_HIT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> done); // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hit) |-> (instr == '0)); // R8
  AST_PROBE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (probes >= CNT_W'(1)) && (probes <= CNT_W'(ENTRIES))); // R7
  AST_INVALID_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_first && !ent_valid) |=> (done && !hit && probes == CNT_W'(1))); // R3
  AST_ACCEPT_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> (probe_first && !ready)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ready && !probe_active)); // R9
endmodule

bind linkcache_fetch linkcache_fetch_chk #(
  .ENTRIES(ENTRIES), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_accept(req_accept), .ready(ready),
  .done(done), .hit(hit), .instr(instr), .probes(probes),
  .probe_active(probe_active), .probe_first(probe_first), .ent_valid(ent_valid)
);

// File: tb/linkcache_fetch_tb.sv
module linkcache_fetch_tb;
  localparam int CLK_HALF = 5;
  localparam int NENT = 8;

  typedef struct {
    logic        hit;
    logic [31:0] instr;
    logic [3:0]  probes;
    int          acc;
    string       rtag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] addr = '0;
  logic        ready, done, hit;
  logic [31:0] instr;
  logic [3:0]  probes;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic        wr_valid = 1'b0;
  logic [26:0] wr_tag = '0;
  logic [31:0] wr_instr = '0;
  logic        wr_link_ok = 1'b0;
  logic [2:0]  wr_link = '0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;
  exp_t sb[$];

  logic        m_valid [NENT];
  logic [26:0] m_tag   [NENT];
  logic [31:0] m_data  [NENT];
  logic        m_lok   [NENT];
  logic [2:0]  m_link  [NENT];

  linkcache_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .ready(ready),
    .done(done), .hit(hit), .instr(instr), .probes(probes),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_tag(wr_tag),
    .wr_instr(wr_instr), .wr_link_ok(wr_link_ok), .wr_link(wr_link)
  );

  always #CLK_HALF clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string r, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [26:0] t, input logic [2:0] i,
                                     input logic [1:0] off);
    return {t, i, off};
  endfunction

  // expected result from the requirements: head needs valid, chain trusts tags
  function automatic void predict(input logic [31:0] a, output logic h,
                                  output logic [31:0] d, output logic [3:0] n);
    logic [26:0] t;
    logic [2:0]  p;
    t = a[31:5];
    p = a[4:2];
    h = 1'b0; d = '0; n = 4'd1;
    if (!m_valid[p]) return;
    for (int k = 1; k <= NENT; k++) begin
      n = 4'(k);
      if (m_tag[p] == t) begin
        h = 1'b1; d = m_data[p];
        return;
      end
      if (!m_lok[p] || k == NENT) return;
      p = m_link[p];
    end
  endfunction

  task automatic load(input logic [2:0] i, input logic v, input logic [26:0] t,
                      input logic [31:0] d, input logic lok, input logic [2:0] l);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_valid = v; wr_tag = t;
    wr_instr = d; wr_link_ok = lok; wr_link = l;
    m_valid[i] = v; m_tag[i] = t; m_data[i] = d; m_lok[i] = lok; m_link[i] = l;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fetch(input string r, input logic [31:0] a);
    exp_t e;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; addr = a;
    @(posedge clk);
    #1;
    predict(a, e.hit, e.instr, e.probes);
    e.acc = cyc;
    e.rtag = r;
    sb.push_back(e);
    req = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (sb.size() != 0 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  // monitor: compare each response against the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) begin
        if (sb.size() == 0) begin
          checks++;
          fails++;
          $display("FAIL R9 response with none pending: actual done=1 expected done=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(e.rtag, "hit", {31'd0, hit}, {31'd0, e.hit});
          chk(e.rtag, "instr", instr, e.instr);
          chk(e.rtag, "probes", {28'd0, probes}, {28'd0, e.probes});
          chk("R8", "latency", 32'(cyc - e.acc), 32'(e.probes));
        end
      end else begin
        chk("R8", "hit idle", {31'd0, hit}, 32'd0);
        chk("R8", "instr idle", instr, 32'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NENT; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = '0; m_data[i] = '0; m_lok[i] = 1'b0; m_link[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready", {31'd0, ready}, 32'd1);
    chk("R1", "done", {31'd0, done}, 32'd0);
    chk("R1", "hit", {31'd0, hit}, 32'd0);

    // R10 loader fills: chain 0->6->7 (tail invalid), loop 3<->4, invalid head 2
    load(3'd0, 1'b1, 27'h10, 32'hA000_0000, 1'b1, 3'd6);
    load(3'd6, 1'b0, 27'h11, 32'hA000_0006, 1'b1, 3'd7);
    load(3'd7, 1'b0, 27'h12, 32'hA000_0007, 1'b0, 3'd0);
    load(3'd1, 1'b1, 27'h20, 32'hB000_0001, 1'b0, 3'd0);
    load(3'd2, 1'b0, 27'h30, 32'hC000_0002, 1'b1, 3'd3);
    load(3'd3, 1'b1, 27'h40, 32'hD000_0003, 1'b1, 3'd4);
    load(3'd4, 1'b1, 27'h41, 32'hD000_0004, 1'b1, 3'd3);

    fetch("R4", mk(27'h10, 3'd0, 2'b00));
    fetch("R4", mk(27'h20, 3'd1, 2'b00));
    fetch("R5", mk(27'h11, 3'd0, 2'b00));
    fetch("R5", mk(27'h12, 3'd0, 2'b00));
    fetch("R6", mk(27'h13, 3'd0, 2'b00));
    fetch("R6", mk(27'h21, 3'd1, 2'b00));
    fetch("R3", mk(27'h30, 3'd2, 2'b00));
    fetch("R3", mk(27'h55, 3'd5, 2'b00));
    fetch("R5", mk(27'h41, 3'd3, 2'b00));
    fetch("R7", mk(27'h99, 3'd3, 2'b00));
    fetch("R7", mk(27'h98, 3'd4, 2'b00));
    fetch("R2", mk(27'h10, 3'd0, 2'b11));
    fetch("R2", mk(27'h12, 3'd0, 2'b10));
    drain();

    // R9: request raised mid-walk must be dropped
    fetch("R5", mk(27'h12, 3'd0, 2'b00));
    @(negedge clk);
    chk("R9", "ready busy", {31'd0, ready}, 32'd0);
    req = 1'b1; addr = mk(27'h20, 3'd1, 2'b00);
    @(negedge clk);
    req = 1'b0;
    drain();

    // R10: rewrite an entry, then read the new contents
    load(3'd5, 1'b1, 27'h77, 32'hE000_0005, 1'b0, 3'd0);
    fetch("R10", mk(27'h77, 3'd5, 2'b01));
    load(3'd0, 1'b1, 27'h10, 32'hF000_0000, 1'b0, 3'd0);
    fetch("R10", mk(27'h11, 3'd0, 2'b00));
    fetch("R10", mk(27'h10, 3'd0, 2'b00));
    drain();

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule